// File: doc/BRIEF.md
# Byte Rotate, Shift and Bit Operation Unit

This is a purely combinational datapath slice for an 8-bit processor core. It performs the second-byte (prefixed) group of bit manipulation instructions on one operand byte. The core hands it the second opcode byte, the operand value and the current flag nibble. The unit returns the new byte, the new flag nibble and a strobe that says whether the result must be stored back. It also reports which operand the opcode names, so the core knows where to fetch from and where to store to. The fetch and store themselves happen outside the unit.

A separate mode input reuses the same logic for the four single-byte accumulator rotates. In that mode the zero flag is always forced low.

Top module: `rsb_unit`

## Requirements
- R1: Outside accumulator mode, op_code[7:6] picks the group: 0 shift/rotate, 1 bit test, 2 bit reset, 3 bit set. op_code[5:3] is the shift kind in group 0 and the bit index in the other groups. opnd_sel equals op_code[2:0], in operand order B,C,D,E,H,L,memory-at-HL,A. mem_op is high exactly when opnd_sel is 6.
- R2: Shift kind 0 rotates left circularly and kind 1 rotates right circularly. In both, the bit that leaves lands in the vacated bit and in carry.
- R3: Shift kind 2 rotates left through carry and kind 3 rotates right through carry. The incoming carry fills the vacated bit, and the bit that leaves becomes the new carry.
- R4: Shift kind 4 shifts left, fills bit 0 with 0 and puts old bit 7 into carry. Shift kind 5 shifts right, keeps bit 7 and puts old bit 0 into carry.
- R5: Shift kind 7 shifts right, fills bit 7 with 0 and puts old bit 0 into carry.
- R6: Shift kind 6 exchanges the two nibbles and clears subtract, half-carry and carry.
- R7: In group 0, zero is 1 exactly when the result is 0x00, subtract and half-carry are cleared, and wr_en is 1. Flags are packed as bit3 zero, bit2 subtract, bit1 half-carry, bit0 carry.
- R8: Bit test sets zero to the inverse of the chosen bit, clears subtract, sets half-carry and passes carry through. It drives wr_en low, and dout equals din.
- R9: Bit reset clears the chosen bit and bit set sets it. All other bits are kept, flags_out equals flags_in, and wr_en is 1.
- R10: With acc_mode high, op_code[4:3] picks 0 circular left, 1 circular right, 2 left through carry or 3 right through carry, and all other opcode bits are ignored. Zero is forced to 0. Subtract and half-carry are cleared. opnd_sel is 7, mem_op is 0 and wr_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 8 | Second opcode byte, or the rotate selector in accumulator mode |
| acc_mode | input | 1 | Selects the accumulator-only rotate behaviour |
| din | input | DW | Operand byte |
| flags_in | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| dout | output | DW | Result byte |
| flags_out | output | 4 | Updated flags, same packing |
| wr_en | output | 1 | Result must be written back to the operand |
| opnd_sel | output | 3 | Operand the opcode refers to |
| mem_op | output | 1 | Operand is the memory byte addressed by HL |

## Verification
The bench builds the unit with the default DW of 8. That is the only width the octal opcode fields describe, so every opcode, every bit index and every flag combination is within reach. Directed vectors cover the carry boundaries: all-zero and all-ones operands, bit 7 and bit 0 edges, and incoming carry both set and clear. A seeded random sweep then covers the full opcode space in both modes.

// File: rtl/rsb_unit.sv
module rsb_unit #(
  parameter int DW = 8
) (
  input  logic [7:0]    op_code,
  input  logic          acc_mode,
  input  logic [DW-1:0] din,
  input  logic [3:0]    flags_in,
  output logic [DW-1:0] dout,
  output logic [3:0]    flags_out,
  output logic          wr_en,
  output logic [2:0]    opnd_sel,
  output logic          mem_op
);
  localparam int IW = $clog2(DW);
  localparam int HW = DW / 2;

  logic [1:0]    grp;
  logic [2:0]    kind;
  logic [IW-1:0] bidx;
  logic [DW-1:0] mask;
  logic [DW-1:0] res;
  logic          co;
  logic          cin;

  assign grp      = acc_mode ? 2'd0 : op_code[7:6];
  assign kind     = acc_mode ? {1'b0, op_code[4:3]} : op_code[5:3];
  assign bidx     = IW'(op_code[5:3]);
  assign mask     = {{(DW-1){1'b0}}, 1'b1} << bidx;
  assign cin      = flags_in[0];
  assign opnd_sel = acc_mode ? 3'd7 : op_code[2:0];
  assign mem_op   = (opnd_sel == 3'd6);

  always_comb begin
    case (kind)
      3'd0:    begin res = {din[DW-2:0], din[DW-1]};   co = din[DW-1]; end
      3'd1:    begin res = {din[0], din[DW-1:1]};      co = din[0];    end
      3'd2:    begin res = {din[DW-2:0], cin};         co = din[DW-1]; end
      3'd3:    begin res = {cin, din[DW-1:1]};         co = din[0];    end
      3'd4:    begin res = {din[DW-2:0], 1'b0};        co = din[DW-1]; end
      3'd5:    begin res = {din[DW-1], din[DW-1:1]};   co = din[0];    end
      3'd6:    begin res = {din[HW-1:0], din[DW-1:HW]}; co = 1'b0;     end
      default: begin res = {1'b0, din[DW-1:1]};        co = din[0];    end
    endcase
  end

  always_comb begin
    case (grp)
      2'd0: begin
        dout      = res;
        flags_out = {~acc_mode & (res == '0), 1'b0, 1'b0, co};
        wr_en     = 1'b1;
      end
      2'd1: begin
        dout      = din;
        flags_out = {~din[bidx], 1'b0, 1'b1, flags_in[0]};
        wr_en     = 1'b0;
      end
      2'd2: begin
        dout      = din & ~mask;
        flags_out = flags_in;
        wr_en     = 1'b1;
      end
      default: begin
        dout      = din | mask;
        flags_out = flags_in;
        wr_en     = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk #(
  parameter int DW = 8
) (
  input logic [7:0]    op_code,
  input logic          acc_mode,
  input logic [DW-1:0] din,
  input logic [3:0]    flags_in,
  input logic [DW-1:0] dout,
  input logic [3:0]    flags_out,
  input logic          wr_en,
  input logic [2:0]    opnd_sel,
  input logic          mem_op
);
  logic [DW-1:0] one_hot;
  assign one_hot = {{(DW-1){1'b0}}, 1'b1} << op_code[5:3];

  always_comb begin
    // R1
    mem_flag_chk: assert (mem_op == (opnd_sel == 3'd6));
    // R8
    test_nowrite_chk: assert (acc_mode || op_code[7:6] != 2'd1 ||
                              (!wr_en && dout == din && flags_out[0] == flags_in[0]));
    // R9
    bitmod_flags_chk: assert (acc_mode || op_code[7] != 1'b1 ||
                              (wr_en && flags_out == flags_in &&
                               ((dout ^ din) & ~one_hot) == '0));
    // R7
    shift_flags_chk: assert (acc_mode || op_code[7:6] != 2'd0 ||
                             (wr_en && flags_out[2:1] == 2'b00 &&
                              flags_out[3] == (dout == '0)));
    // R10
    acc_zero_chk: assert (!acc_mode ||
                          (flags_out[3:1] == 3'b000 && wr_en && opnd_sel == 3'd7));
    // R6
    swap_carry_chk: assert (acc_mode || op_code[7:3] != 5'b00110 || flags_out[0] == 1'b0);
  end
endmodule

bind rsb_unit rsb_unit_chk #(.DW(DW)) u_chk (
  .op_code(op_code), .acc_mode(acc_mode), .din(din), .flags_in(flags_in),
  .dout(dout), .flags_out(flags_out), .wr_en(wr_en),
  .opnd_sel(opnd_sel), .mem_op(mem_op)
);

// File: tb/rsb_unit_test.sv
module rsb_unit_test;
  logic       clk = 1'b0;
  logic [7:0] op_code;
  logic       acc_mode;
  logic [7:0] din;
  logic [3:0] flags_in;
  logic [7:0] dout;
  logic [3:0] flags_out;
  logic       wr_en;
  logic [2:0] opnd_sel;
  logic       mem_op;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rsb_unit uut (
    .op_code(op_code), .acc_mode(acc_mode), .din(din), .flags_in(flags_in),
    .dout(dout), .flags_out(flags_out), .wr_en(wr_en),
    .opnd_sel(opnd_sel), .mem_op(mem_op)
  );

  function automatic string req_of(input logic [7:0] op, input logic am);
    if (am) return "R10";
    case (op[7:6])
      2'd1: return "R8";
      2'd2, 2'd3: return "R9";
      default: case (op[5:3])
        3'd0, 3'd1: return "R2";
        3'd2, 3'd3: return "R3";
        3'd4, 3'd5: return "R4";
        3'd6: return "R6";
        default: return "R5";
      endcase
    endcase
  endfunction

  // packed {wr, flags[3:0], sel[2:0], mem, data[7:0]}
  function automatic logic [16:0] model(input logic [7:0] op, input logic am,
                                        input logic [7:0] d, input logic [3:0] f);
    logic [7:0] r; logic c; logic [3:0] nf; logic w; logic [2:0] s; int k; int b;
    c = f[0]; w = 1'b1; r = d; nf = f;
    s = am ? 3'd7 : op[2:0];
    b = op[5:3];
    if (am || op[7:6] == 2'd0) begin
      k = am ? int'(op[4:3]) : int'(op[5:3]);
      case (k)
        0: begin c = d[7]; r = (d << 1) | (d >> 7); end
        1: begin c = d[0]; r = (d >> 1) | (d << 7); end
        2: begin c = d[7]; r = (d << 1) | {7'd0, f[0]}; end
        3: begin c = d[0]; r = (d >> 1) | {f[0], 7'd0}; end
        4: begin c = d[7]; r = d << 1; end
        5: begin c = d[0]; r = (d >> 1) | (d & 8'h80); end
        6: begin c = 1'b0; r = {d[3:0], d[7:4]}; end
        default: begin c = d[0]; r = d >> 1; end
      endcase
      nf = {(!am && r == 8'd0), 1'b0, 1'b0, c};
    end else if (op[7:6] == 2'd1) begin
      w = 1'b0; nf = {~d[b], 1'b0, 1'b1, f[0]};
    end else if (op[7:6] == 2'd2) begin
      r = d & ~(8'd1 << b);
    end else begin
      r = d | (8'd1 << b);
    end
    return {w, nf, s, (s == 3'd6), r};
  endfunction

  task automatic apply(input logic [7:0] op, input logic am,
                       input logic [7:0] d, input logic [3:0] f);
    logic [16:0] exp, got;
    @(negedge clk);
    op_code = op; acc_mode = am; din = d; flags_in = f;
    #1;
    exp = model(op, am, d, f);
    got = {wr_en, flags_out, opnd_sel, mem_op, dout};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (R1 R7 decode/flags) op=%o am=%0b din=%h fin=%b got=%h exp=%h",
               req_of(op, am), op, am, d, f, got, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    op_code = 8'd0; acc_mode = 1'b0; din = 8'd0; flags_in = 4'd0;
    // reset-state style check: all-zero inputs, R2 circular left on zero (R7 zero flag)
    apply(8'o000, 1'b0, 8'h00, 4'h0);
    // R2 circular edges
    apply(8'o000, 1'b0, 8'h80, 4'h0);
    apply(8'o011, 1'b0, 8'h01, 4'h0);
    // R3 through carry
    apply(8'o022, 1'b0, 8'h80, 4'h0);
    apply(8'o033, 1'b0, 8'h00, 4'h1);
    // R4 arithmetic shifts
    apply(8'o044, 1'b0, 8'hFF, 4'h0);
    apply(8'o055, 1'b0, 8'h81, 4'h0);
    // R6 swap
    apply(8'o066, 1'b0, 8'hA5, 4'hF);
    apply(8'o067, 1'b0, 8'h00, 4'hF);
    // R5 logical right
    apply(8'o077, 1'b0, 8'h01, 4'h0);
    // R8 bit test, carry kept, no write
    apply(8'o176, 1'b0, 8'h7F, 4'h1);
    apply(8'o100, 1'b0, 8'h01, 4'h0);
    // R9 reset / set, flags unchanged
    apply(8'o277, 1'b0, 8'hFF, 4'hA);
    apply(8'o300, 1'b0, 8'h00, 4'h5);
    // R10 accumulator rotates, zero forced low, upper opcode bits ignored
    apply(8'o007, 1'b1, 8'h00, 4'h0);
    apply(8'o327, 1'b1, 8'h80, 4'h0);
    apply(8'o237, 1'b1, 8'h01, 4'h0);
    // R1 random sweep across all opcodes and modes
    for (int i = 0; i < 3000; i++) begin
      apply(8'($urandom), ($urandom % 5) == 0, 8'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule